// File: doc/BRIEF.md
# Programmable-Latency Synchronous Delay Line

This block delays a stream of words by a number of clock cycles chosen by a host. One clock drives the whole block. On every cycle in which the active-low enable is asserted, one word is stored in an internal circular buffer and one word is read from it. The distance between the read and write positions sets the delay, so the delay holds steady for as long as the enable is shared by both sides.

The host writes a latency value through a one-word configuration port. The value stays pending until the host raises the arm input. The rising edge of arm commits the value and sets the channel up for a countdown. The countdown starts on the first enabled cycle after that commit. This covers both orders of events: arm raised first and the enable lowered later, or the enable already low when arm is raised. Until the countdown expires, the output is held at zero and the valid flag stays low. After that, each output word is the input word from exactly the committed number of enabled cycles earlier.

Top module: `prog_delay_line`

## Requirements
- R1: While reset is asserted and after it is released, `dout` reads zero and `dout_vld` reads 0 until a countdown expires.
- R2: Once `dout_vld` is 1, the word on `dout` after the n-th enabled edge counted from the countdown start (the first edge is n = 0) equals `din` sampled at edge n-L, where L is the committed latency.
- R3: During the countdown, `dout_vld` is 0 and `dout` is zero. `dout_vld` first reads 1 after edge n = L, and it rises only on an enabled edge.
- R4: If arm rises while `en_n` is 1, the countdown begins at the first later edge with `en_n` = 0, and the output stays invalid while the block waits.
- R5: If arm rises while `en_n` is already 0, the commit edge itself does not count, the output goes invalid at that edge, and the countdown begins at the next enabled edge.
- R6: A rising edge of arm with no configuration write since the last commit is ignored, and the running output continues unchanged.
- R7: A committed value below 2 acts as a latency of 2. A value above DEPTH acts as DEPTH. Values from 2 to DEPTH are used as written.
- R8: A configuration write while the channel runs does not change the output. The new value takes effect only at the next arm rising edge, which drops `dout_vld` at that edge and restarts the countdown.
- R9: While `en_n` is 1, `dout` and `dout_vld` hold their values and no latency cycle is counted, except at an arm commit, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for writes and reads |
| rst_n | input | 1 | Synchronous active-low reset |
| en_n | input | 1 | Active-low enable for write, read and countdown |
| arm | input | 1 | Commit strobe, acts on its rising edge |
| cfg_we | input | 1 | Host strobe that stores `cfg_wdata` as the pending latency |
| cfg_wdata | input | $clog2(DEPTH+1) | Host latency value in enabled cycles |
| din | input | W | Input word |
| dout | output | W | Delayed word, zero while not valid |
| dout_vld | output | 1 | Output word is valid |

## Verification
Each output check sits at a known distance from its stimulus. An arm commit is visible one edge after arm rises. The first valid word appears after the L-th enabled edge counted from the countdown start. In steady state, the word seen after enabled edge n is the one sampled at edge n-L. The bench keeps a history of every word it drives on an enabled edge, indexed by that count, and reads the expected word from it. It samples one nanosecond after each rising edge and changes inputs at the same moment, so every check reads values that are settled. Disabled cycles do not advance the count. The bench therefore expects the held values there and expects the same history index after the stream resumes.

// File: rtl/prog_delay_line.sv
`timescale 1ns/1ps
module prog_delay_line #(
  parameter int W     = 8,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  input  logic          arm,
  input  logic          cfg_we,
  input  logic [LW-1:0] cfg_wdata,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic          dout_vld
);
  localparam int MIN_LAT = 2;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_COUNT, S_RUN} st_t;

  st_t           st;
  logic [W-1:0]  mem [DEPTH];
  logic [W-1:0]  rd_q;
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] lat_pend, lat_act, cnt;
  logic          pend_new, arm_q;
  logic          go, commit;

  function automatic logic [LW-1:0] clamp_lat(input logic [LW-1:0] v);
    if (v < LW'(MIN_LAT)) return LW'(MIN_LAT);
    if (v > LW'(DEPTH))   return LW'(DEPTH);
    return v;
  endfunction

  assign go     = ~en_n;
  assign commit = arm & ~arm_q & pend_new;
  assign rp     = AW'({1'b0, wp} - (lat_act - 1'b1));

  always_ff @(posedge clk) begin
    if (go) begin
      mem[wp] <= din;
      rd_q    <= mem[rp];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      wp       <= '0;
      lat_pend <= '0;
      lat_act  <= LW'(MIN_LAT);
      cnt      <= '0;
      pend_new <= 1'b0;
      arm_q    <= 1'b0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      arm_q <= arm;
      if (go) wp <= wp + 1'b1;
      if (commit) begin
        lat_act  <= clamp_lat(lat_pend);
        pend_new <= 1'b0;
        st       <= S_ARMED;
        dout     <= '0;
        dout_vld <= 1'b0;
      end else if (go) begin
        case (st)
          S_ARMED: begin
            st  <= S_COUNT;
            cnt <= lat_act - 1'b1;
          end
          S_COUNT: begin
            if (cnt == '0) begin
              st       <= S_RUN;
              dout     <= rd_q;
              dout_vld <= 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          S_RUN:   dout <= rd_q;
          default: ;
        endcase
      end
      if (cfg_we) begin
        lat_pend <= cfg_wdata;
        pend_new <= 1'b1;
      end
    end
  end
endmodule

module prog_delay_line_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_n,
  input logic         arm,
  input logic         cfg_we,
  input logic [W-1:0] dout,
  input logic         dout_vld
);
  logic arm_prev, pend, fire;

  assign fire = arm & ~arm_prev & pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_prev <= 1'b0;
      pend     <= 1'b0;
    end else begin
      arm_prev <= arm;
      if (fire)   pend <= 1'b0;
      if (cfg_we) pend <= 1'b1;
    end
  end

  // R3
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_vld |-> dout == '0);

  // R3
  rise_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_vld) |-> $past(!en_n));

  // R8
  commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !dout_vld);

  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n && !fire |=> $stable(dout) && $stable(dout_vld));

  // R6
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld && !fire |=> dout_vld);
endmodule

bind prog_delay_line prog_delay_line_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_n(en_n), .arm(arm), .cfg_we(cfg_we),
  .dout(dout), .dout_vld(dout_vld)
);

// File: tb/sim_prog_delay_line.sv
`timescale 1ns/1ps
module sim_prog_delay_line;
  localparam int W     = 8;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_n = 1'b1;
  logic          arm = 1'b0;
  logic          cfg_we = 1'b0;
  logic [LW-1:0] cfg_wdata = '0;
  logic [W-1:0]  din = '0;
  logic [W-1:0]  dout;
  logic          dout_vld;

  int checks = 0;
  int errors = 0;
  int k = 0;
  int eff = 2;
  int dat = 7;
  bit done = 0;
  logic [W-1:0] hist [0:255];

  always #2.5 clk = ~clk;

  prog_delay_line #(.W(W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .arm(arm), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .din(din), .dout(dout), .dout_vld(dout_vld)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clamp(int v);
    if (v < 2) return 2;
    if (v > DEPTH) return DEPTH;
    return v;
  endfunction

  task automatic next_dat();
    dat = (dat * 29 + 17) % 256;
    din = W'(dat);
  endtask

  task automatic en_cycle(string early, string late);
    next_dat();
    en_n = 1'b0;
    hist[k] = din;
    step();
    if (k >= eff) begin
      check(late, int'(dout_vld), 1);
      check(late, int'(dout), int'(hist[k - eff]));
    end else begin
      check(early, int'(dout_vld), 0);
      check(early, int'(dout), 0);
    end
    k++;
  endtask

  task automatic arm_idle(int p, string tag);
    cfg_we = 1'b1; cfg_wdata = LW'(p); en_n = 1'b1;
    step();
    cfg_we = 1'b0; arm = 1'b1;
    step();
    check(tag, int'(dout_vld), 0);
    arm = 1'b0;
    step();
    check(tag, int'(dout_vld), 0);
    check(tag, int'(dout), 0);
    eff = clamp(p); k = 0;
  endtask

  task automatic arm_busy(int p, string tag);
    cfg_we = 1'b1; cfg_wdata = LW'(p); en_n = 1'b0; next_dat();
    step();
    cfg_we = 1'b0; arm = 1'b1; next_dat();
    step();
    check(tag, int'(dout_vld), 0);
    check(tag, int'(dout), 0);
    arm = 1'b0;
    eff = clamp(p); k = 0;
  endtask

  initial begin
    repeat (3) step();
    // R1
    check("R1", int'(dout_vld), 0);
    check("R1", int'(dout), 0);
    rst_n = 1'b1;
    step();
    check("R1", int'(dout_vld), 0);
    check("R1", int'(dout), 0);

    for (int p = 0; p < 32; p++) begin
      string late;
      late = (p < 2 || p > DEPTH) ? "R7" : "R2";
      if (p % 2 == 0) arm_idle(p, "R4");
      else            arm_busy(p, "R5");
      for (int i = 0; i < eff + 3; i++) en_cycle("R3", late);
    end

    arm_idle(5, "R4");
    for (int i = 0; i < 8; i++) en_cycle("R3", "R2");
    // R6: arm edge with no prior write
    arm = 1'b1;
    for (int i = 0; i < 3; i++) en_cycle("R6", "R6");
    arm = 1'b0;
    for (int i = 0; i < 3; i++) en_cycle("R6", "R6");

    // R9: disabled cycles freeze the output
    begin
      logic [W-1:0] hold_d;
      logic         hold_v;
      hold_d = dout; hold_v = dout_vld;
      en_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
        next_dat();
        step();
        check("R9", int'(dout), int'(hold_d));
        check("R9", int'(dout_vld), int'(hold_v));
      end
      for (int i = 0; i < 6; i++) en_cycle("R9", "R9");
    end

    // R8: write while running, no effect until arm
    cfg_we = 1'b1; cfg_wdata = LW'(9);
    en_cycle("R8", "R8");
    cfg_we = 1'b0;
    for (int i = 0; i < 5; i++) en_cycle("R8", "R8");
    arm = 1'b1; en_n = 1'b0; next_dat();
    step();
    check("R8", int'(dout_vld), 0);
    check("R8", int'(dout), 0);
    arm = 1'b0;
    eff = 9; k = 0;
    for (int i = 0; i < 13; i++) en_cycle("R8", "R8");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule